// File: doc/BRIEF.md
# Bus Capture to Byte-Split Word Emitter

This block sits between a fast processor's external write bus and a slower capture port that reads 16-bit words from an asynchronous 48 MHz clock. Every processor write carries 16 data bits and a 7-bit type tag. The block takes each write in the bus clock domain and stores the 23-bit capture in a dual-clock FIFO. In its own emit clock domain it turns each capture into two 16-bit words. Each word holds one data byte, the full tag, and a flag that names the byte it carries.

The reader samples without a shared clock, so each word comes with a strobe. The strobe stays high for a parameterised number of emit-clock cycles, and successive strobes are spaced by a second, larger parameter. The defaults, 5 and 20 cycles of a 144 MHz emit clock, give about 35 ns of high time and about 139 ns between words. These exceed 1.5 and 6 periods of the 48 MHz reader.

The processor may write faster than the output drains. When that happens the FIFO absorbs the bursts. A write that arrives while the FIFO is full is discarded and raises a sticky flag, which stays set until the bus-side reset.

Top module: `bus_word_splitter`

## Requirements
- R1: The first word emitted for a capture is {bit15=0, bits14:8=tag, bits7:0=data[7:0]}.
- R2: The second word for the same capture is {bit15=1, bits14:8=tag, bits7:0=data[15:8]} and follows the first directly, with no other word between them.
- R3: Captures leave the block in the order the bus wrote them, and none is lost while the FIFO has room.
- R4: Each strobe pulse stays high for exactly HIGH_CYC emit-clock cycles.
- R5: Rising edges of the strobe are at least SPACE_CYC emit cycles apart, and exactly SPACE_CYC apart between the two words of one capture.
- R6: `out_word` does not change while `out_strobe` is high, and it holds its value until the next rising edge.
- R7: A write that arrives while the FIFO is full is dropped and sets `drop_seen`. `drop_seen` stays set until the bus reset. When the reader is held in reset, exactly 2**FIFO_AW writes are accepted. Once the FIFO has drained, new writes are accepted again.
- R8: After reset, `out_strobe`, `out_word` and `drop_seen` are all zero.
- R9: No strobe is produced while no capture is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Processor bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset of the bus domain |
| bus_we | input | 1 | Write strobe, one capture per cycle it is high |
| bus_data | input | 16 | Write data |
| bus_tag | input | 7 | Write type tag from the address lines |
| drop_seen | output | 1 | Sticky flag: a write was dropped because the FIFO was full |
| emit_clk | input | 1 | Emit-side clock that counts the pacing |
| emit_rst_n | input | 1 | Active-low asynchronous reset of the emit domain |
| out_word | output | 16 | Word toward the capture port |
| out_strobe | output | 1 | Valid strobe for `out_word` |

## Verification
The bench pushes captures whose bytes are all-zero, all-one and mixed. If the byte order or the half flag were swapped, the first word of a pair would hold the high byte and the model comparison would catch it. The bench holds the reader in reset while it writes past the FIFO depth, so exactly one depth's worth must come out. An off-by-one full test would either emit an extra word or lose the last one, and a lost sticky flag would read zero after the drain. Strobe width and spacing are measured on every edge, so a wrong compare in the pacing counter would show up as a short or long pulse or as a gap that is too close. Idle periods before and after traffic catch a design that strobes with an empty FIFO.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

    // Which byte of the capture the current word carries (also bit 15 of the word)
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    // Pacer activity
    typedef enum logic {
        PACE_IDLE = 1'b0,
        PACE_BUSY = 1'b1
    } pace_e;

endpackage

// File: rtl/ptr_sync.sv
module ptr_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo #(
    parameter int DW = 23,
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_din,
    output logic          overflow,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_pop,
    output logic          rd_empty,
    output logic [DW-1:0] rd_dout
);

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] FULL_MASK = {2'b11, {(PW-2){1'b0}}};

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          ovf;
    } wside_t;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } rside_t;

    wside_t ws_d, ws_q;
    rside_t rs_d, rs_q;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rgray_in_w;
    logic [PW-1:0] wgray_in_r;
    logic          wr_full;
    logic          wr_push;
    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] rbin_nx;

    // ---------------- write domain ----------------
    assign wr_full = (ws_q.gray == (rgray_in_w ^ FULL_MASK));
    assign wr_push = wr_en && !wr_full;

    always_comb begin
        ws_d    = ws_q;
        wbin_nx = ws_q.bin + PW'(1);
        if (wr_push) begin
            ws_d.bin  = wbin_nx;
            ws_d.gray = wbin_nx ^ (wbin_nx >> 1);
        end
        if (wr_en && wr_full) begin
            ws_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            ws_q <= '0;
        end else begin
            ws_q <= ws_d;
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_push) begin
            mem[ws_q.bin[AW-1:0]] <= wr_din;
        end
    end

    assign overflow = ws_q.ovf;

    // ---------------- read domain ----------------
    assign rd_empty = (rs_q.gray == wgray_in_r);
    assign rd_dout  = mem[rs_q.bin[AW-1:0]];

    always_comb begin
        rs_d    = rs_q;
        rbin_nx = rs_q.bin + PW'(1);
        if (rd_pop && !rd_empty) begin
            rs_d.bin  = rbin_nx;
            rs_d.gray = rbin_nx ^ (rbin_nx >> 1);
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    // ---------------- pointer crossings ----------------
    ptr_sync #(.W(PW), .STAGES(2)) u_w2r (
        .clk   (rclk),
        .rst_n (rrst_n),
        .d     (ws_q.gray),
        .q     (wgray_in_r)
    );

    ptr_sync #(.W(PW), .STAGES(2)) u_r2w (
        .clk   (wclk),
        .rst_n (wrst_n),
        .d     (rs_q.gray),
        .q     (rgray_in_w)
    );

    // ---------------- assertions ----------------
    // R7: a write into a full FIFO leaves the pointer alone and raises the flag
    a_r7_full_drop: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_en && wr_full) |=> ($stable(ws_q.bin) && overflow));

    // R7: the drop flag is sticky
    a_r7_flag_sticky: assert property (@(posedge wclk) disable iff (!wrst_n)
        overflow |=> overflow);

    // R3: the write pointer moves by one Gray step at most
    a_r3_gray_step: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(ws_q.gray ^ $past(ws_q.gray)) <= 1);

    // R9: the consumer never pops an empty FIFO
    a_r9_no_underflow: assert property (@(posedge rclk) disable iff (!rrst_n)
        rd_pop |-> !rd_empty);

endmodule

// File: rtl/word_pacer.sv
module word_pacer
    import splitter_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int TAG_W     = 7,
    parameter int HIGH_CYC  = 5,   // strobe high time, must be below SPACE_CYC
    parameter int SPACE_CYC = 20,  // rise-to-rise spacing of words
    localparam int HALF_W   = DATA_W / 2,
    localparam int WORD_W   = 1 + TAG_W + HALF_W,
    localparam int CAP_W    = TAG_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [CAP_W-1:0]  fifo_data,
    output logic              fifo_pop,
    output logic [WORD_W-1:0] out_word,
    output logic              out_strobe
);

    localparam int CNT_W = $clog2(SPACE_CYC + 1);
    localparam int GAP_W = CNT_W + 1;

    typedef struct packed {
        pace_e              mode;
        half_e              half;
        logic [CAP_W-1:0]   cap;
        logic [CNT_W-1:0]   cnt;
        logic [WORD_W-1:0]  word;
        logic               strobe;
    } pace_t;

    pace_t ps_d, ps_q;

    function automatic logic [WORD_W-1:0] low_word(input logic [CAP_W-1:0] c);
        return {HALF_LO, c[CAP_W-1:DATA_W], c[HALF_W-1:0]};
    endfunction

    function automatic logic [WORD_W-1:0] high_word(input logic [CAP_W-1:0] c);
        return {HALF_HI, c[CAP_W-1:DATA_W], c[DATA_W-1:HALF_W]};
    endfunction

    always_comb begin
        ps_d     = ps_q;
        fifo_pop = 1'b0;
        case (ps_q.mode)
            PACE_IDLE: begin
                if (!fifo_empty) begin
                    fifo_pop    = 1'b1;
                    ps_d.cap    = fifo_data;
                    ps_d.word   = low_word(fifo_data);
                    ps_d.strobe = 1'b1;
                    ps_d.cnt    = CNT_W'(1);
                    ps_d.half   = HALF_LO;
                    ps_d.mode   = PACE_BUSY;
                end
            end
            default: begin
                ps_d.cnt = ps_q.cnt + CNT_W'(1);
                if (ps_q.cnt == CNT_W'(HIGH_CYC)) begin
                    ps_d.strobe = 1'b0;
                end
                if (ps_q.cnt == CNT_W'(SPACE_CYC)) begin
                    if (ps_q.half == HALF_LO) begin
                        ps_d.word   = high_word(ps_q.cap);
                        ps_d.strobe = 1'b1;
                        ps_d.cnt    = CNT_W'(1);
                        ps_d.half   = HALF_HI;
                    end else if (!fifo_empty) begin
                        fifo_pop    = 1'b1;
                        ps_d.cap    = fifo_data;
                        ps_d.word   = low_word(fifo_data);
                        ps_d.strobe = 1'b1;
                        ps_d.cnt    = CNT_W'(1);
                        ps_d.half   = HALF_LO;
                    end else begin
                        ps_d.mode = PACE_IDLE;
                        ps_d.cnt  = '0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign out_word   = ps_q.word;
    assign out_strobe = ps_q.strobe;

    // ---------------- assertion support: pulse and gap meters ----------------
    logic             prev_q;
    logic             seen_q;
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            seen_q <= 1'b0;
            gap_q  <= '0;
            run_q  <= '0;
        end else begin
            prev_q <= out_strobe;
            if (out_strobe && !prev_q) begin
                gap_q  <= GAP_W'(1);
                seen_q <= 1'b1;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + GAP_W'(1);
            end
            run_q <= out_strobe ? run_q + GAP_W'(1) : '0;
        end
    end

    // R4: every pulse lasts HIGH_CYC cycles
    a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_strobe && prev_q) |-> (run_q == GAP_W'(HIGH_CYC)));

    // R5: rising edges keep the minimum spacing
    a_r5_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && !prev_q && seen_q) |-> (gap_q >= GAP_W'(SPACE_CYC)));

    // R6: the word is steady while the strobe is high
    a_r6_word_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && prev_q) |-> $stable(out_word));

    // R2: a high-byte word follows a low-byte word with the same tag
    a_r2_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && !prev_q && out_word[WORD_W-1]) |->
        (!$past(out_word[WORD_W-1]) &&
         ($past(out_word[WORD_W-2:HALF_W]) == out_word[WORD_W-2:HALF_W])));

    // R1: a pop always starts a low-byte word
    a_r1_pop_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> (out_strobe && !out_word[WORD_W-1]));

endmodule

// File: rtl/bus_word_splitter.sv
module bus_word_splitter #(
    parameter int DATA_W    = 16,
    parameter int TAG_W     = 7,
    parameter int FIFO_AW   = 6,
    parameter int HIGH_CYC  = 5,
    parameter int SPACE_CYC = 20,
    localparam int WORD_W   = 1 + TAG_W + DATA_W / 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [TAG_W-1:0]  bus_tag,
    output logic              drop_seen,
    input  logic              emit_clk,
    input  logic              emit_rst_n,
    output logic [WORD_W-1:0] out_word,
    output logic              out_strobe
);

    localparam int CAP_W = TAG_W + DATA_W;

    logic [CAP_W-1:0] cap_in;
    logic [CAP_W-1:0] cap_out;
    logic             cap_empty;
    logic             cap_pop;

    assign cap_in = {bus_tag, bus_data};

    dual_clk_fifo #(.DW(CAP_W), .AW(FIFO_AW)) u_fifo (
        .wclk     (bus_clk),
        .wrst_n   (bus_rst_n),
        .wr_en    (bus_we),
        .wr_din   (cap_in),
        .overflow (drop_seen),
        .rclk     (emit_clk),
        .rrst_n   (emit_rst_n),
        .rd_pop   (cap_pop),
        .rd_empty (cap_empty),
        .rd_dout  (cap_out)
    );

    word_pacer #(
        .DATA_W    (DATA_W),
        .TAG_W     (TAG_W),
        .HIGH_CYC  (HIGH_CYC),
        .SPACE_CYC (SPACE_CYC)
    ) u_pacer (
        .clk        (emit_clk),
        .rst_n      (emit_rst_n),
        .fifo_empty (cap_empty),
        .fifo_data  (cap_out),
        .fifo_pop   (cap_pop),
        .out_word   (out_word),
        .out_strobe (out_strobe)
    );

endmodule

// File: tb/bus_word_splitter_tb.sv
`timescale 1ns/100ps
module bus_word_splitter_tb;

    localparam int HIGH  = 5;
    localparam int SPACE = 20;
    localparam int DEPTH = 64;

    logic        bus_clk = 1'b0;
    logic        emit_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        emit_rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_data = '0;
    logic [6:0]  bus_tag = '0;
    logic        drop_seen;
    logic [15:0] out_word;
    logic        out_strobe;

    always #2.0 emit_clk = ~emit_clk;   // 250 MHz
    always #3.5 bus_clk  = ~bus_clk;

    bus_word_splitter u_dut (
        .bus_clk    (bus_clk),
        .bus_rst_n  (bus_rst_n),
        .bus_we     (bus_we),
        .bus_data   (bus_data),
        .bus_tag    (bus_tag),
        .drop_seen  (drop_seen),
        .emit_clk   (emit_clk),
        .emit_rst_n (emit_rst_n),
        .out_word   (out_word),
        .out_strobe (out_strobe)
    );

    int checks = 0;
    int failures = 0;
    int rises = 0;
    logic [15:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model, compared every emit clock ----------------
    bit          m_prev = 0;
    bit          m_seen = 0;
    int          m_gap = 0;
    int          m_run = 0;
    logic [15:0] m_last = '0;

    always @(negedge emit_clk) begin
        if (!emit_rst_n) begin
            m_prev = 0; m_seen = 0; m_gap = 0; m_run = 0; m_last = out_word;
        end else begin
            if (out_strobe && !m_prev) begin
                logic [15:0] ew;
                rises++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 strobe with nothing queued", 32'(out_word), 32'hFFFF);
                    ew = out_word;
                end else begin
                    ew = exp_q.pop_front();
                    chk(out_word == ew, ew[15] ? "R2 high-byte word" : "R1 low-byte word",
                        32'(out_word), 32'(ew));
                end
                if (m_seen) begin
                    chk(m_gap >= SPACE, "R5 minimum spacing", 32'(m_gap), 32'(SPACE));
                    if (ew[15]) chk(m_gap == SPACE, "R5 pair spacing", 32'(m_gap), 32'(SPACE));
                end
                m_gap = 1; m_seen = 1; m_run = 1;
            end else begin
                m_gap++;
                if (out_strobe) begin
                    m_run++;
                    chk(out_word == m_last, "R6 word steady while high", 32'(out_word), 32'(m_last));
                end else begin
                    if (m_prev) chk(m_run == HIGH, "R4 pulse width", 32'(m_run), 32'(HIGH));
                    chk(out_word == m_last, "R6 word held between pulses", 32'(out_word), 32'(m_last));
                end
            end
            m_last = out_word;
            m_prev = out_strobe;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic put(input logic [6:0] tag, input logic [15:0] data, input bit expect_it);
        @(negedge bus_clk);
        bus_we = 1'b1; bus_tag = tag; bus_data = data;
        if (expect_it) begin
            exp_q.push_back({1'b0, tag, data[7:0]});
            exp_q.push_back({1'b1, tag, data[15:8]});
        end
    endtask

    task automatic idle_bus();
        @(negedge bus_clk);
        bus_we = 1'b0;
    endtask

    task automatic drain(input int limit);
        for (int i = 0; i < limit && exp_q.size() != 0; i++) @(negedge emit_clk);
        repeat (2 * SPACE + 10) @(negedge emit_clk);
        chk(exp_q.size() == 0, "R3 every accepted capture emitted in order",
            32'(exp_q.size()), 32'd0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge emit_clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (5) @(negedge emit_clk);
        bus_rst_n = 1'b1;
        emit_rst_n = 1'b1;
        @(negedge emit_clk);
        chk(out_strobe == 1'b0, "R8 strobe low after reset", 32'(out_strobe), 32'd0);
        chk(out_word == 16'h0, "R8 word zero after reset", 32'(out_word), 32'd0);
        chk(drop_seen == 1'b0, "R8 drop flag clear after reset", 32'(drop_seen), 32'd0);

        // R9: idle period
        repeat (60) @(negedge emit_clk);
        chk(rises == 0, "R9 no strobe while idle", 32'(rises), 32'd0);

        // single captures with edge byte patterns (R1, R2)
        put(7'h5A, 16'hA53C, 1); idle_bus();
        drain(2000);
        put(7'h00, 16'h0000, 1); idle_bus();
        put(7'h7F, 16'hFFFF, 1); idle_bus();
        put(7'h01, 16'h00FF, 1); idle_bus();
        put(7'h40, 16'hFF00, 1); idle_bus();
        drain(4000);

        // back-to-back burst (R3, R5 exact spacing)
        for (int i = 0; i < 12; i++) put(7'((i * 13) % 128), 16'((i * 16'h1357) ^ 16'hA5A5), 1);
        idle_bus();
        drain(8000);
        chk(drop_seen == 1'b0, "R7 no drop while room", 32'(drop_seen), 32'd0);

        // overflow: reader held in reset, both sides restarted together
        @(negedge emit_clk);
        bus_rst_n = 1'b0;
        emit_rst_n = 1'b0;
        repeat (4) @(negedge bus_clk);
        bus_rst_n = 1'b1;
        repeat (4) @(negedge bus_clk);
        chk(drop_seen == 1'b0, "R8 drop flag cleared by bus reset", 32'(drop_seen), 32'd0);
        for (int i = 0; i < DEPTH + 6; i++) put(7'(i + 3), 16'(i * 16'h0101 + 16'h2001), i < DEPTH);
        idle_bus();
        repeat (3) @(negedge bus_clk);
        chk(drop_seen == 1'b1, "R7 drop flag set on full", 32'(drop_seen), 32'd1);
        chk(out_strobe == 1'b0, "R9 no strobe while reader held", 32'(out_strobe), 32'd0);
        @(negedge emit_clk);
        emit_rst_n = 1'b1;
        drain(12000);
        chk(drop_seen == 1'b1, "R7 drop flag sticky", 32'(drop_seen), 32'd1);

        // space freed: a new write is accepted again
        put(7'h2B, 16'h6C93, 1); idle_bus();
        drain(2000);
        chk(rises == 2 * (1 + 4 + 12 + DEPTH + 1), "R3 total word count",
            32'(rises), 32'(2 * (1 + 4 + 12 + DEPTH + 1)));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule